// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block is the digital control side of an analog-to-digital converter front end. Software reaches it through a small register bus with a write strobe, an address and write data, and a combinational read port. The main control register holds four things: the channel to convert, a continuous-repeat flag, an enable for buffering the reference out to a pin, and the low bit of a two-bit reference-level code. Its top bit starts a conversion and also reports that one is running. The high bit of the reference code sits in a second register at the next address.

When a conversion starts, the block counts system clocks. On the last counted clock it captures a sample from an input port, which stands in for the analog converter. It then raises a one-cycle done pulse and sets a sticky valid flag. The first conversion after a start takes a fixed long interval. In continuous mode, each later conversion takes a much shorter interval, and conversions keep repeating until software clears the continuous flag. The channel number sent to the converter is latched when each conversion begins, so software may rewrite the channel field at any time without disturbing the conversion in flight.

Top module: `adc_seq_ctrl`

## Requirements
- R1: The control register sits at address 0. Its bit 7 is enable/busy, bit 6 is the reference low bit, bit 5 is the reference-buffer enable, bit 4 is continuous mode and bits 3:0 are the channel. All of its bits reset to 0, and bits 6:0 read back exactly as last written.
- R2: Address 1 reads bit 0 as the reference high bit, which resets to 1, and bits 7:1 as 0. Addresses 2 and 3 read as 0, and writes to them change nothing.
- R3: A write to address 0 with bit 7 set starts a conversion, and bit 7 reads 1 from the next cycle. A write with bit 7 clear leaves a running conversion and the busy bit unchanged.
- R4: For a single conversion, the sample is captured on the FIRST_CYCLES-th rising edge after the start edge (5129 by default). Bit 7 clears on that same edge unless continuous mode is set.
- R5: A start written while a conversion is running restarts the full FIRST_CYCLES count, and the interrupted conversion produces no sample.
- R6: In continuous mode, each conversion after the first completes REPEAT_CYCLES edges (256 by default) after the previous one. If the continuous bit is cleared, the conversion in progress finishes and bit 7 clears with it.
- R7: `result_done` is high for exactly one cycle per captured sample. `result_data` changes only together with that pulse. `result_valid` rises with the first capture and stays high until reset.
- R8: `conv_channel` takes the channel value at a start, and the current channel field at each continuous reload. A channel written mid-conversion does not change it.
- R9: `conv_ref_sel` is {high bit, low bit}, with codes 00 external, 01 internal 1.0 V, 10 internal 2.0 V (the reset value) and 11 reserved, passed through unchanged. `conv_ref_buf_en` follows control bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| conv_data | input | SAMPLE_W | Sample from the converter model |
| conv_channel | output | 4 | Channel held for the running conversion |
| conv_ref_sel | output | 2 | Reference level code |
| conv_ref_buf_en | output | 1 | Reference buffer to pin enable |
| result_data | output | SAMPLE_W | Last captured sample |
| result_valid | output | 1 | At least one sample captured since reset |
| result_done | output | 1 | One-cycle capture pulse |

## Verification
The bench first rewrites the channel and clears the enable bit partway through a single conversion. A design that latched the channel late, or let a zero clear the busy bit, would switch the converter input or end the conversion early. It then restarts a conversion well before its end. A wrong design would emit a stray sample at the original deadline, or measure the restarted conversion from the first start. Continuous mode is timed over several repeats, and the continuous bit is then cleared mid-conversion: an off-by-one counter shows up as a drifting period, and a design that stopped at once would cut off the final sample. The reserved reference code and the unused addresses are written as well, to catch masking or aliasing.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    // Register addresses and the start bit position (decoded by the sequencer)
    localparam int unsigned CTRL_ADDR  = 0;
    localparam int unsigned REFHI_ADDR = 1;
    localparam int unsigned START_BIT  = 7;
    localparam int unsigned CHAN_W     = 4;

    // Writable fields of the control register, bits 6:0
    typedef struct packed {
        logic              ref_lo;
        logic              ref_buf;
        logic              cont;
        logic [CHAN_W-1:0] chan;
    } ctl_fields_t;

endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
    import adc_seq_pkg::*;
#(
    parameter int unsigned ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              busy,
    output ctl_fields_t       fields,
    output logic              ref_hi,
    output logic              start,
    output logic [7:0]        bus_rdata
);

    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] A_REFHI = ADDR_W'(REFHI_ADDR);

    typedef struct packed {
        ctl_fields_t f;
        logic        hi;
    } reg_state_t;

    reg_state_t st_q, st_d;

    logic hit_ctrl, hit_refhi;

    always_comb begin
        hit_ctrl  = bus_we && (bus_addr == A_CTRL);
        hit_refhi = bus_we && (bus_addr == A_REFHI);
        st_d = st_q;
        if (hit_ctrl) begin
            st_d.f = ctl_fields_t'(bus_wdata[6:0]);
        end
        if (hit_refhi) begin
            st_d.hi = bus_wdata[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.f  <= '0;
            st_q.hi <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (bus_addr)
            A_CTRL:  bus_rdata = {busy, st_q.f};
            A_REFHI: bus_rdata = {7'b0, st_q.hi};
            default: bus_rdata = 8'h00;
        endcase
    end

    assign start  = hit_ctrl && bus_wdata[START_BIT];
    assign fields = st_q.f;
    assign ref_hi = st_q.hi;

endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer
    import adc_seq_pkg::*;
#(
    parameter int unsigned FIRST_CYCLES  = 5129,
    parameter int unsigned REPEAT_CYCLES = 256,
    parameter int unsigned SAMPLE_W      = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [CHAN_W-1:0]   start_chan,
    input  logic                cont,
    input  logic [CHAN_W-1:0]   cur_chan,
    input  logic [SAMPLE_W-1:0] conv_data,
    output logic                busy,
    output logic [CHAN_W-1:0]   chan_out,
    output logic [SAMPLE_W-1:0] sample,
    output logic                valid,
    output logic                done
);

    localparam int unsigned LONGEST = (FIRST_CYCLES > REPEAT_CYCLES) ? FIRST_CYCLES : REPEAT_CYCLES;
    localparam int unsigned CNT_W   = $clog2(LONGEST + 1);
    localparam logic [CNT_W-1:0] FIRST_LOAD  = CNT_W'(FIRST_CYCLES - 1);
    localparam logic [CNT_W-1:0] REPEAT_LOAD = CNT_W'(REPEAT_CYCLES - 1);

    typedef struct packed {
        logic                busy;
        logic [CNT_W-1:0]    cnt;
        logic [CHAN_W-1:0]   chan;
        logic [SAMPLE_W-1:0] sample;
        logic                valid;
        logic                done;
    } tmr_state_t;

    tmr_state_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (start) begin
            // a start or restart always reloads the long first interval
            st_d.busy = 1'b1;
            st_d.cnt  = FIRST_LOAD;
            st_d.chan = start_chan;
        end else if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                st_d.sample = conv_data;
                st_d.valid  = 1'b1;
                st_d.done   = 1'b1;
                if (cont) begin
                    st_d.cnt  = REPEAT_LOAD;
                    st_d.chan = cur_chan;
                end else begin
                    st_d.busy = 1'b0;
                end
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy     = st_q.busy;
    assign chan_out = st_q.chan;
    assign sample   = st_q.sample;
    assign valid    = st_q.valid;
    assign done     = st_q.done;

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int unsigned FIRST_CYCLES  = 5129,
    parameter int unsigned REPEAT_CYCLES = 256,
    parameter int unsigned SAMPLE_W      = 10,
    parameter int unsigned ADDR_W        = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [7:0]          bus_wdata,
    output logic [7:0]          bus_rdata,
    input  logic [SAMPLE_W-1:0] conv_data,
    output logic [3:0]          conv_channel,
    output logic [1:0]          conv_ref_sel,
    output logic                conv_ref_buf_en,
    output logic [SAMPLE_W-1:0] result_data,
    output logic                result_valid,
    output logic                result_done
);

    ctl_fields_t fields;
    logic        ref_hi;
    logic        start;
    logic        busy;

    adc_seq_regs #(
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .busy      (busy),
        .fields    (fields),
        .ref_hi    (ref_hi),
        .start     (start),
        .bus_rdata (bus_rdata)
    );

    adc_seq_timer #(
        .FIRST_CYCLES  (FIRST_CYCLES),
        .REPEAT_CYCLES (REPEAT_CYCLES),
        .SAMPLE_W      (SAMPLE_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_chan (bus_wdata[CHAN_W-1:0]),
        .cont       (fields.cont),
        .cur_chan   (fields.chan),
        .conv_data  (conv_data),
        .busy       (busy),
        .chan_out   (conv_channel),
        .sample     (result_data),
        .valid      (result_valid),
        .done       (result_done)
    );

    assign conv_ref_sel    = {ref_hi, fields.ref_lo};
    assign conv_ref_buf_en = fields.ref_buf;

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
    parameter int unsigned SAMPLE_W = 10,
    parameter int unsigned ADDR_W   = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_we,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [7:0]          bus_wdata,
    input logic                busy,
    input logic [3:0]          conv_channel,
    input logic [SAMPLE_W-1:0] result_data,
    input logic                result_valid,
    input logic                result_done
);

    logic wr_start;
    assign wr_start = bus_we && (bus_addr == '0) && bus_wdata[7];

    assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |=> busy);

    assert_clear_with_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> result_done);

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        result_done |=> !result_done);

    assert_data_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !result_done |-> $stable(result_data));

    assert_valid_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        result_done |-> result_valid);

    assert_chan_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !wr_start) |=> ($stable(conv_channel) || result_done));

endmodule

bind adc_seq_ctrl adc_seq_chk #(
    .SAMPLE_W (SAMPLE_W),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .busy         (busy),
    .conv_channel (conv_channel),
    .result_data  (result_data),
    .result_valid (result_valid),
    .result_done  (result_done)
);

// File: tb/adc_seq_ctrl_tb.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb;

    localparam int FIRST  = 5129;
    localparam int REPEAT = 256;
    localparam int SW     = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_we = 1'b0;
    logic [1:0]    bus_addr = 2'd0;
    logic [7:0]    bus_wdata = 8'h00;
    logic [7:0]    bus_rdata;
    logic [SW-1:0] conv_data = '0;
    logic [3:0]    conv_channel;
    logic [1:0]    conv_ref_sel;
    logic          conv_ref_buf_en;
    logic [SW-1:0] result_data;
    logic          result_valid;
    logic          result_done;

    adc_seq_ctrl u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .bus_we          (bus_we),
        .bus_addr        (bus_addr),
        .bus_wdata       (bus_wdata),
        .bus_rdata       (bus_rdata),
        .conv_data       (conv_data),
        .conv_channel    (conv_channel),
        .conv_ref_sel    (conv_ref_sel),
        .conv_ref_buf_en (conv_ref_buf_en),
        .result_data     (result_data),
        .result_valid    (result_valid),
        .result_done     (result_done)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, got, exp, cyc);
        end
    endtask

    // behavioural reference model
    bit          m_busy, m_lo, m_ext, m_cont, m_hi, m_valid, m_done;
    bit [3:0]    m_chan, m_lat;
    bit [SW-1:0] m_samp;
    int          m_rem;
    int          start_cyc;
    int          done_times[$];

    always @(posedge clk) begin
        bit started;
        cyc++;
        if (!rst_n) begin
            m_busy = 0; m_lo = 0; m_ext = 0; m_cont = 0; m_hi = 1;
            m_valid = 0; m_done = 0; m_chan = 0; m_lat = 0; m_samp = 0; m_rem = 0;
        end else begin
            started = bus_we && bus_addr == 2'd0 && bus_wdata[7];
            m_done = 0;
            if (m_busy && !started) begin
                m_rem--;
                if (m_rem == 0) begin
                    m_samp = conv_data; m_valid = 1; m_done = 1;
                    done_times.push_back(cyc);
                    if (m_cont) begin
                        m_rem = REPEAT; m_lat = m_chan;
                    end else begin
                        m_busy = 0;
                    end
                end
            end
            if (bus_we && bus_addr == 2'd0) begin
                m_lo = bus_wdata[6]; m_ext = bus_wdata[5];
                m_cont = bus_wdata[4]; m_chan = bus_wdata[3:0];
            end
            if (started) begin
                m_busy = 1; m_rem = FIRST; m_lat = bus_wdata[3:0]; start_cyc = cyc;
            end
            if (bus_we && bus_addr == 2'd1) m_hi = bus_wdata[0];
        end
    end

    // per-cycle comparison, away from the clock edge
    always begin
        logic [7:0] exp_rd;
        @(posedge clk);
        #2;
        if (rst_n) begin
            case (bus_addr)
                2'd0:    exp_rd = {m_busy, m_lo, m_ext, m_cont, m_chan};
                2'd1:    exp_rd = {7'b0, m_hi};
                default: exp_rd = 8'h00;
            endcase
            chk(bus_addr == 2'd0 ? "R1 ctrl read" : "R2 aux read", bus_rdata, exp_rd);
            chk("R8 channel", conv_channel, m_lat);
            chk("R9 ref code", conv_ref_sel, {m_hi, m_lo});
            chk("R9 ref buffer", conv_ref_buf_en, m_ext);
            chk("R7 sample", result_data, m_samp);
            chk("R7 valid", result_valid, m_valid);
            chk("R4 done", result_done, m_done);
        end
    end

    always @(negedge clk) conv_data <= conv_data + SW'(37);

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 2'd0; bus_wdata = 8'h00;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic wait_dones(input int n);
        int guard = 0;
        while (done_times.size() < n && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] v;
        int s;
        repeat (3) @(negedge clk);
        // reset state (R1, R2, R7)
        chk("R1 reset ctrl", bus_rdata, 8'h00);
        chk("R7 reset valid", result_valid, 1'b0);
        rst_n = 1'b1;
        rd(2'd1, v); chk("R2 ref high reset", v, 8'h01);
        chk("R9 default ref code", conv_ref_sel, 2'b10);

        // field write without start (R1, R3)
        wr(2'd0, 8'h35);
        rd(2'd0, v); chk("R1 fields readback", v, 8'h35);
        repeat (20) @(negedge clk);
        chk("R3 no start without bit 7", result_done, 1'b0);

        // single conversion with mid-run channel rewrite (R3, R4, R8)
        wr(2'd0, 8'h83);
        rd(2'd0, v); chk("R3 busy after start", v[7], 1'b1);
        repeat (2000) @(negedge clk);
        wr(2'd0, 8'h09);
        chk("R8 channel held", conv_channel, 4'h3);
        rd(2'd0, v); chk("R3 zero write keeps busy", v, 8'h89);
        wait_dones(1);
        chk("R4 single latency", done_times[0] - start_cyc, FIRST);
        repeat (3) @(negedge clk);
        rd(2'd0, v); chk("R4 busy cleared", v, 8'h09);

        // restart (R5)
        wr(2'd0, 8'h82);
        repeat (1000) @(negedge clk);
        wr(2'd0, 8'h84);
        s = start_cyc;
        wait_dones(2);
        chk("R5 restart latency", done_times[1] - s, FIRST);
        repeat (1100) @(negedge clk);
        chk("R5 single sample after restart", done_times.size(), 2);

        // continuous mode, then stop (R6)
        wr(2'd0, 8'h96);
        s = start_cyc;
        wait_dones(6);
        chk("R6 first continuous", done_times[2] - s, FIRST);
        for (int i = 3; i < 6; i++) chk("R6 repeat period", done_times[i] - done_times[i-1], REPEAT);
        repeat (50) @(negedge clk);
        wr(2'd0, 8'h06);
        rd(2'd0, v); chk("R6 still busy after cont cleared", v[7], 1'b1);
        repeat (600) @(negedge clk);
        chk("R6 one final sample", done_times.size(), 7);
        rd(2'd0, v); chk("R6 idle after stop", v, 8'h06);

        // reference codes (R9)
        wr(2'd1, 8'h00); #2 chk("R9 external code", conv_ref_sel, 2'b00);
        wr(2'd0, 8'h40); #2 chk("R9 1.0V code", conv_ref_sel, 2'b01);
        wr(2'd1, 8'hFF); #2 chk("R9 reserved code", conv_ref_sel, 2'b11);
        wr(2'd0, 8'h20); #2 chk("R9 buffer enable", conv_ref_buf_en, 1'b1);

        // unused addresses (R2)
        wr(2'd2, 8'hFF);
        wr(2'd3, 8'hFF);
        rd(2'd2, v); chk("R2 addr 2 reads zero", v, 8'h00);
        rd(2'd3, v); chk("R2 addr 3 reads zero", v, 8'h00);
        rd(2'd0, v); chk("R2 ctrl untouched", v, 8'h20);
        rd(2'd1, v); chk("R2 aux untouched", v, 8'h01);
        chk("R2 no conversion", result_done, 1'b0);

        repeat (5) @(negedge clk);
        summary();
        $finish;
    end

endmodule